// File: doc/BRIEF.md
# Port-2 Handshake Pin Controller

This block drives four pins of a microcontroller's second I/O port. After reset each pin simply shows the bit last written to it by the local processor. Two commands change this. Each command is a one-cycle strobe. The flags command turns the two low pins into host interrupt requests. One request shows that the output buffer is full. The other shows that the input buffer is ready to accept data. The DMA command turns the third pin into a DMA request. It turns the fourth pin into an active-low acknowledge input, and that input selects the data buffers during DMA cycles.

In the handshake modes the written port bits still matter. On the two flag pins a written 0 holds the pin low, and a written 1 lets the status through. On the request pin a written 1 raises the request. The request then stays up until the host finishes a read or write with the acknowledge low, or until the DMA command is issued again. A finished host access is detected on the clock after its strobe returns high. The buffers themselves and the DMA controller are outside this block.

Top module: `pin_handshake_ctl`

## Requirements
- R1: After reset both modes are off, the four port bits are all 1, `pin_out` equals 4'b1111, `pin3_oe` is 1 and `buf_sel` equals the inverse of `host_cs_n`.
- R2: With a mode off, each pin it governs shows the port bit last written. Bit k of `port_wdata` goes to `pin_out[k]`, and the new value appears at the output after the clock edge on which `port_we` is sampled high.
- R3: In flags mode, `pin_out[0]` is port bit 0 AND `obf`. A written 0 holds the pin low whatever the state of `obf`.
- R4: In flags mode, `pin_out[1]` is port bit 1 AND NOT `ibf`. A written 0 holds the pin low whatever the state of `ibf`.
- R5: In DMA mode, `pin_out[2]` shows the request flag. A port write with bit 2 set raises the flag. A port write with bit 2 clear leaves the flag unchanged.
- R6: In DMA mode, when a host read or write strobe that was low while `dack_n` was low returns high, the request flag is low on the output one clock later. A strobe with `dack_n` high leaves the flag unchanged.
- R7: The DMA command clears the request flag on the next edge. If a port write with bit 2 set arrives in the same cycle, the clear wins.
- R8: In DMA mode `pin3_oe` is 0, and `buf_sel` = NOT `host_cs_n` OR NOT `dack_n`. Outside DMA mode `dack_n` has no effect on `buf_sel`.
- R9: Both modes stay on once set. Issuing a command again keeps its mode on, and only reset turns a mode off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_we | input | 1 | Port write strobe from the local processor |
| port_wdata | input | 4 | Port bits for pins 0..3 |
| en_flags_cmd | input | 1 | One-cycle flags-mode command |
| en_dma_cmd | input | 1 | One-cycle DMA-mode command, also clears the request |
| ibf | input | 1 | Input buffer full status |
| obf | input | 1 | Output buffer full status |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| dack_n | input | 1 | DMA acknowledge from pin 3, active low |
| pin_out | output | 4 | Values driven on pins 0..3 |
| pin3_oe | output | 1 | Output enable for pin 3 |
| buf_sel | output | 1 | Data buffer select, active high |

## Verification
A wrong mode bit is visible at once on the combinational pin outputs and on `buf_sel`. For this reason every port-bit value is checked against every combination of status, acknowledge and chip select in all four mode combinations. A request flag that fails to clear or fails to hold shows up on `pin_out[2]` exactly one clock after the edge that should have changed it. The bench samples at that clock. A mistake in the edge-detect registers shows up as a clear that is missing, or as a clear that happens during an access without acknowledge.

// File: rtl/pin_handshake_ctl.sv
module pin_handshake_ctl #(
  parameter logic [3:0] PORT_RST = 4'hF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_we,
  input  logic [3:0] port_wdata,
  input  logic       en_flags_cmd,
  input  logic       en_dma_cmd,
  input  logic       ibf,
  input  logic       obf,
  input  logic       host_cs_n,
  input  logic       host_rd_n,
  input  logic       host_wr_n,
  input  logic       dack_n,
  output logic [3:0] pin_out,
  output logic       pin3_oe,
  output logic       buf_sel
);

  logic [3:0] port_q;
  logic       flag_mode, dma_mode, drq;
  logic       rd_q, wr_q, dack_q;
  logic       ack_done;

  assign ack_done = dack_q & ((host_rd_n & ~rd_q) | (host_wr_n & ~wr_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q    <= PORT_RST;
      flag_mode <= 1'b0;
      dma_mode  <= 1'b0;
      drq       <= 1'b0;
      rd_q      <= 1'b1;
      wr_q      <= 1'b1;
      dack_q    <= 1'b0;
    end else begin
      if (port_we) port_q <= port_wdata;
      if (en_flags_cmd) flag_mode <= 1'b1;
      if (en_dma_cmd)   dma_mode  <= 1'b1;
      if (en_dma_cmd || ack_done) drq <= 1'b0;
      else if (port_we && port_wdata[2]) drq <= 1'b1;
      rd_q   <= host_rd_n;
      wr_q   <= host_wr_n;
      dack_q <= dma_mode & ~dack_n;
    end
  end

  assign pin_out[0] = flag_mode ? (port_q[0] & obf)  : port_q[0];
  assign pin_out[1] = flag_mode ? (port_q[1] & ~ibf) : port_q[1];
  assign pin_out[2] = dma_mode  ? drq                : port_q[2];
  assign pin_out[3] = port_q[3];
  assign pin3_oe    = ~dma_mode;
  assign buf_sel    = ~host_cs_n | (dma_mode & ~dack_n);

endmodule

// File: rtl/pin_handshake_ctl_chk.sv
module pin_handshake_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       port_we,
  input logic [3:0] port_wdata,
  input logic       en_dma_cmd,
  input logic       ibf,
  input logic       obf,
  input logic       host_cs_n,
  input logic       host_rd_n,
  input logic       host_wr_n,
  input logic [3:0] pin_out,
  input logic       pin3_oe,
  input logic       buf_sel,
  input logic       flag_mode,
  input logic       dma_mode,
  input logic       drq,
  input logic       rd_q,
  input logic       wr_q,
  input logic       dack_q
);

  logic acked;
  assign acked = dack_q & ((host_rd_n & ~rd_q) | (host_wr_n & ~wr_q));

  AST_OBF_GATED:   assert property (@(posedge clk) disable iff (!rst_n) (flag_mode && !obf) |-> !pin_out[0]); // R3
  AST_IBF_GATED:   assert property (@(posedge clk) disable iff (!rst_n) (flag_mode && ibf) |-> !pin_out[1]); // R4
  AST_DRQ_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) (drq && !en_dma_cmd && !acked) |=> drq); // R5
  AST_DRQ_SET:     assert property (@(posedge clk) disable iff (!rst_n) (port_we && port_wdata[2] && !en_dma_cmd && !acked) |=> drq); // R5
  AST_DRQ_ACK_CLR: assert property (@(posedge clk) disable iff (!rst_n) (dma_mode && acked) |=> (!pin_out[2])); // R6
  AST_DRQ_CMD_CLR: assert property (@(posedge clk) disable iff (!rst_n) en_dma_cmd |=> (!drq && !pin_out[2])); // R7
  AST_DACK_INPUT:  assert property (@(posedge clk) disable iff (!rst_n) dma_mode |-> !pin3_oe); // R8
  AST_CS_SELECTS:  assert property (@(posedge clk) disable iff (!rst_n) !host_cs_n |-> buf_sel); // R8
  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (dma_mode || flag_mode) |=> ($past(dma_mode) -> dma_mode) && ($past(flag_mode) -> flag_mode)); // R9

endmodule

bind pin_handshake_ctl pin_handshake_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .port_we(port_we), .port_wdata(port_wdata),
  .en_dma_cmd(en_dma_cmd), .ibf(ibf), .obf(obf), .host_cs_n(host_cs_n),
  .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .pin_out(pin_out),
  .pin3_oe(pin3_oe), .buf_sel(buf_sel), .flag_mode(flag_mode),
  .dma_mode(dma_mode), .drq(drq), .rd_q(rd_q), .wr_q(wr_q), .dack_q(dack_q)
);

// File: tb/tb_pin_handshake_ctl.sv
module tb_pin_handshake_ctl;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_we = 1'b0;
  logic [3:0] port_wdata = 4'h0;
  logic       en_flags_cmd = 1'b0, en_dma_cmd = 1'b0;
  logic       ibf = 1'b0, obf = 1'b0;
  logic       host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1, dack_n = 1'b1;
  logic [3:0] pin_out;
  logic       pin3_oe, buf_sel;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  pin_handshake_ctl dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] model(bit fm, bit dm, logic [3:0] p, bit rq,
                                       bit i, bit o, bit dk_n, bit cs_n);
    logic [3:0] pins;
    pins[0] = fm ? (p[0] & o)  : p[0];
    pins[1] = fm ? (p[1] & ~i) : p[1];
    pins[2] = dm ? rq : p[2];
    pins[3] = p[3];
    return {!dm, (!cs_n) || (dm && !dk_n), pins};
  endfunction

  function automatic logic [5:0] obs();
    return {pin3_oe, buf_sel, pin_out};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic port_write(logic [3:0] v);
    @(negedge clk); port_we = 1'b1; port_wdata = v;
    @(negedge clk); port_we = 1'b0;
  endtask

  task automatic cmd(bit fl, bit dm);
    @(negedge clk); en_flags_cmd = fl; en_dma_cmd = dm;
    @(negedge clk); en_flags_cmd = 1'b0; en_dma_cmd = 1'b0;
  endtask

  task automatic host_access(bit is_rd, bit with_ack);
    @(negedge clk); dack_n = !with_ack;
    if (is_rd) host_rd_n = 1'b0; else host_wr_n = 1'b0;
    @(negedge clk);
    host_rd_n = 1'b1; host_wr_n = 1'b1;
    @(negedge clk); dack_n = 1'b1;
  endtask

  initial begin
    bit rq;
    do_reset();
    #1 check("R1 reset", obs(), 6'b10_1111);
    host_cs_n = 1'b0; #1 check("R1 reset cs", obs(), 6'b11_1111);
    host_cs_n = 1'b1;

    for (int m = 0; m < 4; m++) begin
      do_reset();
      rq = 1'b0;
      if (m != 0) cmd(m[0], m[1]);
      for (int p = 0; p < 16; p++) begin
        port_write(p[3:0]);
        if (p[2]) rq = 1'b1;
        for (int c = 0; c < 16; c++) begin
          ibf = c[0]; obf = c[1]; dack_n = c[2]; host_cs_n = c[3];
          #1 check(m[1] ? "R5/R8 dma sweep" : (m[0] ? "R3/R4 flags sweep" : "R2 port sweep"),
                   obs(), model(m[0], m[1], p[3:0], rq, c[0], c[1], c[2], c[3]));
        end
        ibf = 1'b0; obf = 1'b0; dack_n = 1'b1; host_cs_n = 1'b1;
      end
    end

    // DMA request sequences
    do_reset(); cmd(1'b0, 1'b1);
    check("R7 cmd leaves drq low", obs(), model(0, 1, 4'hF, 0, 0, 0, 1, 1));
    port_write(4'h4);
    check("R5 set", {5'b0, pin_out[2]}, 6'd1);
    port_write(4'h0);
    check("R5 write0 keeps", {5'b0, pin_out[2]}, 6'd1);
    host_access(1'b1, 1'b0);
    check("R6 rd no ack keeps", {5'b0, pin_out[2]}, 6'd1);
    host_access(1'b0, 1'b0);
    check("R6 wr no ack keeps", {5'b0, pin_out[2]}, 6'd1);
    // read with ack: verify timing edge-by-edge
    @(negedge clk); dack_n = 1'b0; host_rd_n = 1'b0;
    @(negedge clk); host_rd_n = 1'b1;
    #1 check("R6 rd ack before edge", {5'b0, pin_out[2]}, 6'd1);
    @(negedge clk);
    check("R6 rd ack cleared", {5'b0, pin_out[2]}, 6'd0);
    dack_n = 1'b1;
    port_write(4'h4);
    host_access(1'b0, 1'b1);
    check("R6 wr ack cleared", {5'b0, pin_out[2]}, 6'd0);
    port_write(4'h4);
    cmd(1'b0, 1'b1);
    check("R7 repeat cmd clears", {5'b0, pin_out[2]}, 6'd0);
    check("R9 dma stays on", {5'b0, pin3_oe}, 6'd0);
    @(negedge clk); port_we = 1'b1; port_wdata = 4'h4; en_dma_cmd = 1'b1;
    @(negedge clk); port_we = 1'b0; en_dma_cmd = 1'b0;
    check("R7 clear beats set", {5'b0, pin_out[2]}, 6'd0);

    // stickiness and reset
    cmd(1'b1, 1'b0); cmd(1'b1, 1'b0);
    port_write(4'h3); obf = 1'b1; ibf = 1'b1;
    #1 check("R9 flags stays on", {2'b0, pin_out}, 6'b00_0001);
    do_reset();
    #1 check("R9 reset clears modes", obs(), 6'b10_1111);
    obf = 1'b0; ibf = 1'b0;
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule